// File: doc/BRIEF.md
# Branch Trace Record Writer

This block watches retired control-flow events (taken branches, interrupts and exceptions) and turns each one into a three-word branch record. It sends each record to memory over a valid/ready write channel. Records land in a trace buffer at a software-chosen base address. A write index counts the bytes used so far and is compared against a configured byte limit. A small FIFO absorbs events while the write channel is stalled.

Recording is controlled by a trace-enable bit and an interrupt-on-trace bit. Neither bit can be set while the facility is reported unavailable. Recording is paused while system management mode is active. A machine-check event switches it off. Reset or an INIT request clears all recording state. No input describes the processor's addressing mode, so recording continues in real-address mode just as in any other mode.

Top module: `btrace_writer`

## Requirements
- R1: A configuration write loads trace enable from `cfgWrData[0]` and interrupt-on-trace from `cfgWrData[1]`, each ANDed with the inverse of `facUnavail`. Writing 0 always clears. The new values appear one cycle after the write.
- R2: An event is accepted when all of these hold: `evValid` is high, trace enable is set, `smmActive` is low, `bufFull` is clear, the record fits, and the FIFO is not full. An accepted event produces three write beats:
  - the from address at `areaBase + index`;
  - the to address at `+4`;
  - a flags word holding the event kind in bits [1:0] (0 branch, 1 interrupt, 2 exception) with zeros above, at `+8`.
- R3: Events seen while `smmActive` is high are dropped. They change neither `bufFull` nor `fifoOvf`, and they produce no write.
- R4: `mcEvent` clears trace enable in the next cycle and takes priority over a configuration write in the same cycle. Records already queued are still written.
- R5: Reset (`rstN` low) or `initReq` clears both control bits, both status bits, the write index and every queued record. `wrValid` is low in the following cycle.
- R6: `wrIndex` starts at 0. It advances by exactly 12 when the third beat of a record is accepted, and it never changes by any other amount except on a clear.
- R7: A record fits when the reserved index plus 12 is no greater than `bufLimit`. An enabled event that does not fit sets `bufFull`. An accepted event that leaves less than 12 bytes of room also sets it. `bufFull` stays set until a clear, and no event is accepted while it is set.
- R8: An enabled event that fits but finds the FIFO full (FIFO_DEPTH records) is dropped and sets the sticky `fifoOvf`.
- R9: While `wrValid` is high and `wrReady` is low, `wrValid`, `wrAddr` and `wrData` hold steady. Beats leave in event order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| initReq | input | 1 | Synchronous INIT clear |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 2 | [0] trace enable, [1] interrupt-on-trace |
| facUnavail | input | 1 | Facility unavailable; blocks setting the control bits |
| smmActive | input | 1 | Management mode active; events ignored |
| mcEvent | input | 1 | Machine-check pulse; clears trace enable |
| areaBase | input | ADDR_W | Trace buffer base address |
| bufLimit | input | IDX_W | Buffer size limit in bytes |
| evValid | input | 1 | Retired control-flow event strobe |
| evKind | input | 2 | 0 branch, 1 interrupt, 2 exception |
| evFrom | input | ADDR_W | Source address |
| evTo | input | ADDR_W | Target address |
| wrValid | output | 1 | Write beat valid |
| wrReady | input | 1 | Memory accepts beat |
| wrAddr | output | ADDR_W | Beat byte address |
| wrData | output | ADDR_W | Beat data |
| traceEn | output | 1 | Trace enable bit |
| intOnTrace | output | 1 | Interrupt-on-trace bit |
| bufFull | output | 1 | Sticky buffer-full status |
| fifoOvf | output | 1 | Sticky FIFO overflow status |
| wrIndex | output | IDX_W | Committed byte index into the buffer |

## Verification
The assertions take `areaBase` and `bufLimit` to be stable except in a cycle where `initReq` is high. Without that, a stalled beat could change address and the index could exceed a shrunken limit. The bench changes both only together with INIT and otherwise holds them fixed. It restricts `evKind` to the three defined kinds, and it pulses `mcEvent` and `initReq` for one cycle at a time.

// File: rtl/btrace_pkg.sv
package btrace_pkg;
  typedef enum logic [1:0] {
    EV_BRANCH = 2'd0,
    EV_INTR   = 2'd1,
    EV_EXCEPT = 2'd2
  } evKind_t;

  localparam int BEATS_PER_REC = 3;

  typedef struct packed {
    logic clear;
    logic push;
  } ctlStrobe_t;
endpackage

// File: rtl/btrace_ctrl.sv
module btrace_ctrl
  import btrace_pkg::*;
#(
  parameter int IDX_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initReq,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgWrData,
  input  logic             facUnavail,
  input  logic             smmActive,
  input  logic             mcEvent,
  input  logic             evValid,
  input  logic [IDX_W-1:0] bufLimit,
  input  logic             fifoFull,
  output ctlStrobe_t       strobe,
  output logic             traceEn,
  output logic             intOnTrace,
  output logic             bufFull,
  output logic             fifoOvf
);
  localparam int REC_BYTES = BEATS_PER_REC * WORD_BYTES;

  logic [IDX_W-1:0] resIdx;
  logic [IDX_W+1:0] resNext, resAfter, limitExt;
  logic             evLive, roomOk, lastFit, pushEv;

  always_comb begin
    limitExt = {2'b00, bufLimit};
    resNext  = {2'b00, resIdx} + (IDX_W+2)'(REC_BYTES);
    resAfter = resNext + (IDX_W+2)'(REC_BYTES);
    roomOk   = resNext <= limitExt;
    lastFit  = resAfter > limitExt;
    evLive   = evValid & traceEn & ~smmActive & ~bufFull;
    pushEv   = evLive & roomOk & ~fifoFull;
    strobe.clear = initReq;
    strobe.push  = pushEv & ~initReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      traceEn    <= 1'b0;
      intOnTrace <= 1'b0;
      bufFull    <= 1'b0;
      fifoOvf    <= 1'b0;
      resIdx     <= '0;
    end else if (initReq) begin
      traceEn    <= 1'b0;
      intOnTrace <= 1'b0;
      bufFull    <= 1'b0;
      fifoOvf    <= 1'b0;
      resIdx     <= '0;
    end else begin
      if (mcEvent)      traceEn <= 1'b0;
      else if (cfgWrEn) traceEn <= cfgWrData[0] & ~facUnavail;
      if (cfgWrEn) intOnTrace <= cfgWrData[1] & ~facUnavail;
      if (evLive) begin
        if (!roomOk) begin
          bufFull <= 1'b1;
        end else if (fifoFull) begin
          fifoOvf <= 1'b1;
        end else begin
          resIdx <= resNext[IDX_W-1:0];
          if (lastFit) bufFull <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/btrace_dpath.sv
module btrace_dpath
  import btrace_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [1:0]        evKind,
  input  logic [ADDR_W-1:0] evFrom,
  input  logic [ADDR_W-1:0] evTo,
  input  logic [ADDR_W-1:0] areaBase,
  input  logic              wrReady,
  output logic              fifoFull,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] wrData,
  output logic [IDX_W-1:0]  wrIndex
);
  localparam int PTR_W     = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1);
  localparam int ENT_W     = 2 * ADDR_W + 2;
  localparam int REC_BYTES = BEATS_PER_REC * WORD_BYTES;
  localparam bit POW2      = (FIFO_DEPTH & (FIFO_DEPTH - 1)) == 0;

  logic [ENT_W-1:0]  mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr, rdPtrNext, wrPtrNext;
  logic [CNT_W-1:0]  count;
  logic [1:0]        beat;
  logic [ENT_W-1:0]  head;
  logic [ADDR_W-1:0] beatOff;
  logic              fire, recDone;

  generate
    if (POW2) begin : g_wrapFree
      assign rdPtrNext = rdPtr + 1'b1;
      assign wrPtrNext = wrPtr + 1'b1;
    end else begin : g_wrapCmp
      assign rdPtrNext = (rdPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      assign wrPtrNext = (wrPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
    end
  endgenerate

  always_comb begin
    fifoFull = count == CNT_W'(FIFO_DEPTH);
    wrValid  = count != '0;
    head     = mem[rdPtr];
    fire     = wrValid & wrReady;
    recDone  = fire & (beat == 2'd2);
    beatOff  = ADDR_W'(beat) * ADDR_W'(WORD_BYTES);
    wrAddr   = areaBase + ADDR_W'(wrIndex) + beatOff;
    case (beat)
      2'd0:    wrData = head[ENT_W-1:ADDR_W+2];
      2'd1:    wrData = head[ADDR_W+1:2];
      default: wrData = {{(ADDR_W-2){1'b0}}, head[1:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= {evFrom, evTo, evKind};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      count   <= '0;
      beat    <= '0;
      wrIndex <= '0;
    end else if (strobe.clear) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      count   <= '0;
      beat    <= '0;
      wrIndex <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtrNext;
      if (fire) beat <= recDone ? 2'd0 : beat + 2'd1;
      if (recDone) begin
        rdPtr   <= rdPtrNext;
        wrIndex <= wrIndex + IDX_W'(REC_BYTES);
      end
      case ({strobe.push, recDone})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/btrace_writer.sv
module btrace_writer
  import btrace_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initReq,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgWrData,
  input  logic              facUnavail,
  input  logic              smmActive,
  input  logic              mcEvent,
  input  logic [ADDR_W-1:0] areaBase,
  input  logic [IDX_W-1:0]  bufLimit,
  input  logic              evValid,
  input  logic [1:0]        evKind,
  input  logic [ADDR_W-1:0] evFrom,
  input  logic [ADDR_W-1:0] evTo,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] wrData,
  output logic              traceEn,
  output logic              intOnTrace,
  output logic              bufFull,
  output logic              fifoOvf,
  output logic [IDX_W-1:0]  wrIndex
);
  localparam int WORD_BYTES = ADDR_W / 8;

  ctlStrobe_t strobe;
  logic       fifoFull;

  btrace_ctrl #(.IDX_W(IDX_W), .WORD_BYTES(WORD_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .initReq(initReq), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .facUnavail(facUnavail), .smmActive(smmActive),
    .mcEvent(mcEvent), .evValid(evValid), .bufLimit(bufLimit),
    .fifoFull(fifoFull), .strobe(strobe), .traceEn(traceEn),
    .intOnTrace(intOnTrace), .bufFull(bufFull), .fifoOvf(fifoOvf)
  );

  btrace_dpath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .FIFO_DEPTH(FIFO_DEPTH),
                 .WORD_BYTES(WORD_BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .evKind(evKind),
    .evFrom(evFrom), .evTo(evTo), .areaBase(areaBase), .wrReady(wrReady),
    .fifoFull(fifoFull), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrIndex(wrIndex)
  );
endmodule

// File: rtl/btrace_checker.sv
module btrace_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              initReq,
  input logic              cfgWrEn,
  input logic              facUnavail,
  input logic              smmActive,
  input logic              mcEvent,
  input logic [IDX_W-1:0]  bufLimit,
  input logic              wrValid,
  input logic              wrReady,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] wrData,
  input logic              traceEn,
  input logic              intOnTrace,
  input logic              bufFull,
  input logic              fifoOvf,
  input logic [IDX_W-1:0]  wrIndex
);
  localparam int REC_BYTES = 3 * (ADDR_W / 8);

  a_r1_unavail_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && facUnavail) |=> (!traceEn && !intOnTrace));

  a_r3_smm_no_status: assert property (@(posedge clk) disable iff (!rstN)
    (smmActive && !initReq) |=> ($stable(bufFull) && $stable(fifoOvf)));

  a_r4_mc_disables: assert property (@(posedge clk) disable iff (!rstN)
    mcEvent |=> !traceEn);

  a_r5_init_clears: assert property (@(posedge clk) disable iff (!rstN)
    initReq |=> (!traceEn && !intOnTrace && !bufFull && !fifoOvf && !wrValid
                 && wrIndex == '0));

  a_r6_index_step: assert property (@(posedge clk) disable iff (!rstN)
    !initReq |=> (wrIndex == $past(wrIndex) ||
                  wrIndex == $past(wrIndex) + IDX_W'(REC_BYTES)));

  a_r7_full_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !initReq) |=> bufFull);

  a_r7_within_limit: assert property (@(posedge clk) disable iff (!rstN || initReq)
    wrIndex <= bufLimit);

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (fifoOvf && !initReq) |=> fifoOvf);

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady && !initReq) |=>
      (wrValid && $stable(wrAddr) && $stable(wrData)));
endmodule

bind btrace_writer btrace_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .initReq(initReq), .cfgWrEn(cfgWrEn),
  .facUnavail(facUnavail), .smmActive(smmActive), .mcEvent(mcEvent),
  .bufLimit(bufLimit), .wrValid(wrValid), .wrReady(wrReady),
  .wrAddr(wrAddr), .wrData(wrData), .traceEn(traceEn),
  .intOnTrace(intOnTrace), .bufFull(bufFull), .fifoOvf(fifoOvf),
  .wrIndex(wrIndex)
);

// File: tb/test_btrace_writer.sv
module test_btrace_writer;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 16;
  localparam int DEPTH  = 4;
  localparam int REC    = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, initReq, cfgWrEn, facUnavail, smmActive, mcEvent;
  logic [1:0] cfgWrData, evKind;
  logic [ADDR_W-1:0] areaBase, evFrom, evTo, wrAddr, wrData;
  logic [IDX_W-1:0] bufLimit, wrIndex;
  logic evValid, wrValid, wrReady, traceEn, intOnTrace, bufFull, fifoOvf;

  btrace_writer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .FIFO_DEPTH(DEPTH)) i_btrace_writer (
    .clk(clk), .rstN(rstN), .initReq(initReq), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .facUnavail(facUnavail), .smmActive(smmActive),
    .mcEvent(mcEvent), .areaBase(areaBase), .bufLimit(bufLimit),
    .evValid(evValid), .evKind(evKind), .evFrom(evFrom), .evTo(evTo),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData),
    .traceEn(traceEn), .intOnTrace(intOnTrace), .bufFull(bufFull),
    .fifoOvf(fifoOvf), .wrIndex(wrIndex)
  );

  int nChecks = 0, nFail = 0;
  bit mEn, mIot, mFull, mOvf;
  int mRes, mIdx, mPop;
  logic [ADDR_W-1:0] qA[$], qD[$];

  task automatic chk(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit fits(int res);
    return (res + REC) <= int'(bufLimit);
  endfunction

  task automatic clearModel();
    mEn = 0; mIot = 0; mFull = 0; mOvf = 0;
    mRes = 0; mIdx = 0; mPop = 0;
    qA.delete(); qD.delete();
  endtask

  // One clock: scoreboard the write channel before the edge, advance model, return at negedge
  task automatic cyc();
    int pending;
    bit fire;
    #1;
    chk("R9", "wrValid", wrValid, qA.size() != 0);
    if (wrValid && qA.size() != 0) begin
      chk("R2", "wrAddr", wrAddr, qA[0]);
      chk("R2", "wrData", wrData, qD[0]);
    end
    fire = wrValid && wrReady;
    pending = (qA.size() + 2) / 3;
    if (!rstN || initReq) begin
      clearModel();
    end else begin
      if (fire && qA.size() != 0) begin
        void'(qA.pop_front()); void'(qD.pop_front());
        mPop++;
        if (mPop % 3 == 0) mIdx += REC;
      end
      if (evValid && mEn && !smmActive && !mFull) begin
        if (!fits(mRes)) mFull = 1;
        else if (pending == DEPTH) mOvf = 1;
        else begin
          qA.push_back(areaBase + mRes);     qD.push_back(evFrom);
          qA.push_back(areaBase + mRes + 4); qD.push_back(evTo);
          qA.push_back(areaBase + mRes + 8); qD.push_back({30'd0, evKind});
          mRes += REC;
          if (!fits(mRes)) mFull = 1;
        end
      end
      if (mcEvent) mEn = 0;
      else if (cfgWrEn) mEn = cfgWrData[0] & ~facUnavail;
      if (cfgWrEn) mIot = cfgWrData[1] & ~facUnavail;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic status(string req);
    chk(req, "traceEn", traceEn, mEn);
    chk(req, "intOnTrace", intOnTrace, mIot);
    chk(req, "bufFull", bufFull, mFull);
    chk(req, "fifoOvf", fifoOvf, mOvf);
    chk(req, "wrIndex", wrIndex, mIdx);
  endtask

  task automatic cfg(logic [1:0] d);
    cfgWrEn = 1; cfgWrData = d; cyc(); cfgWrEn = 0;
  endtask

  task automatic ev(logic [1:0] k);
    evValid = 1; evKind = k; evFrom = $urandom; evTo = $urandom;
    cyc(); evValid = 0;
  endtask

  task automatic init(logic [IDX_W-1:0] lim);
    initReq = 1; bufLimit = lim; cyc(); initReq = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(8 * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clearModel();
    rstN = 0; initReq = 0; cfgWrEn = 0; cfgWrData = 0; facUnavail = 0;
    smmActive = 0; mcEvent = 0; areaBase = 32'h8000_0000; bufLimit = 16'h1000;
    evValid = 0; evKind = 0; evFrom = 0; evTo = 0; wrReady = 1;
    @(negedge clk);
    cyc(); cyc();
    rstN = 1;
    cyc();
    status("R5");

    // R1: unavailable facility blocks setting both bits
    facUnavail = 1; cfg(2'b11); status("R1");
    facUnavail = 0; cfg(2'b11); status("R1");

    // R2/R6: three kinds back to back, then drain
    ev(2'd0); ev(2'd1); ev(2'd2);
    idle(12);
    status("R6");
    chk("R6", "index after three records", wrIndex, 36);

    // R3: management mode drops events
    smmActive = 1; ev(2'd0); ev(2'd2); smmActive = 0;
    idle(4);
    status("R3");

    // R8: stalled channel fills the FIFO
    wrReady = 0;
    for (int i = 0; i < 6; i++) ev(2'(i % 3));
    status("R8");
    chk("R8", "fifoOvf", fifoOvf, 1);
    wrReady = 1; idle(16);
    status("R9");

    // R4: machine check wins over a same-cycle enable write
    mcEvent = 1; cfgWrEn = 1; cfgWrData = 2'b01; cyc();
    mcEvent = 0; cfgWrEn = 0;
    status("R4");
    chk("R4", "traceEn after mc", traceEn, 0);
    ev(2'd1); idle(4); status("R4");

    // R7: limit of 40 bytes admits three records
    init(16'd40); status("R5");
    cfg(2'b01);
    for (int i = 0; i < 5; i++) ev(2'd0);
    idle(16);
    status("R7");
    chk("R7", "bufFull", bufFull, 1);
    chk("R7", "wrIndex at limit", wrIndex, 36);

    // R5: INIT while records are queued
    init(16'h1000); cfg(2'b11);
    wrReady = 0; ev(2'd2); ev(2'd1);
    init(16'h1000);
    status("R5");
    chk("R5", "wrValid after init", wrValid, 0);
    wrReady = 1;

    // Random phase
    init(16'h0C00); cfg(2'b01);
    for (int c = 0; c < 6000; c++) begin
      evValid   = ($urandom % 100) < 40;
      evKind    = 2'($urandom % 3);
      evFrom    = $urandom;
      evTo      = $urandom;
      wrReady   = ($urandom % 100) < 70;
      smmActive = ($urandom % 100) < 5;
      facUnavail = ($urandom % 100) < 20;
      cfgWrEn   = ($urandom % 100) < 2;
      cfgWrData = 2'($urandom % 4) | 2'b01;
      mcEvent   = ($urandom % 1000) < 2;
      initReq   = ($urandom % 1000) < 2;
      cyc();
      status("R2");
    end
    evValid = 0; cfgWrEn = 0; mcEvent = 0; initReq = 0; wrReady = 1; smmActive = 0;
    idle(20);
    status("R9");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule